// File: doc/BRIEF.md
# Latched-Address SRAM Bus Sequencer

This block carries out single-byte reads and writes to an SRAM that sits behind two external address latches. The SRAM and both latches share one 8-bit bus. Every strobe to the latches or to the SRAM comes from a 3-to-8 decoder. The block places a 3-bit select code on the decoder inputs while the decoder's active-low gate is high. It then pulls the gate low for a set number of cycles and raises it again. Only the gate-low window activates the decoded strobe.

Each access runs in three phases, always in the same order:
1. The low address byte goes onto the bus and is latched.
2. The high address byte goes onto the bus and is latched.
3. The data phase runs. A write drives the data byte together with the write code. A read releases the data lines and samples them near the end of the gate-low window.

The address reachable this way is 16 bits wide. When an access finishes, every bus pin is released and a one-cycle completion pulse is raised.

The parameter `SETUP_CYC` sets how many cycles each select code is held with the gate high before the gate falls. The parameter `GATE_LOW` sets how many cycles the gate stays low. `GATE_LOW` must be at least 2, so that at least one idle cycle separates the falling gate from the read sample.

Top module: `latched_sram_seq`

## Requirements
- R1: While reset is asserted and after it is released, `ctl_oe`, `bus_doe` and `done` are 0 and `gate_n` is 1.
- R2: Each access makes exactly three gate-low pulses. The first uses select code 3'b010 with the address bits 7:0 on `bus_dout`. The second uses select code 3'b011 with the address bits 15:8 on `bus_dout`.
- R3: The third pulse of a write uses select code 3'b111, with `bus_doe` high and the write byte on `bus_dout`. The third pulse of a read uses select code 3'b000.
- R4: Before each gate-low pulse, the select code for that pulse is held, with `ctl_oe` high and `gate_n` high, for exactly `SETUP_CYC` cycles. The gate then stays low for exactly `GATE_LOW` cycles.
- R5: Throughout the data phase of a read, `bus_doe` is 0. `rdata` takes the value of `bus_din` from the last gate-low cycle of the read strobe.
- R6: `done` is high for exactly one cycle. It is seen `3*(SETUP_CYC+GATE_LOW+1)` cycles after the clock edge at which the request was accepted.
- R7: While `done` is high and afterwards, until the next request, `ctl_oe` and `bus_doe` are 0 and `gate_n` is 1.
- R8: A request raised while an access is in progress is ignored. No strobe is issued for it, and its address and data leave no trace in memory.
- R9: `rdata` keeps its value from the end of a read until a later read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, accepted only when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| bus_dout | output | 8 | Shared bus output value |
| bus_doe | output | 1 | Output enable of the shared data lines |
| bus_din | input | 8 | Shared bus input value |
| gate_n | output | 1 | Decoder gate, active low |
| sel | output | 3 | Decoder select code |
| ctl_oe | output | 1 | Output enable of gate and select lines |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of an access. It must leave no effect at all. The stimulus raises such a request for a never-written address partway through an ongoing access. Later it reads that address back and expects the untouched background value.

A read that samples at the wrong moment is also hard to see. To expose it, the bench's decoder and SRAM model drive a poison byte whenever the read strobe is inactive. The bench then sweeps all 256 low-address values, and all 256 high-address values, with arithmetically derived data.

// File: rtl/latched_sram_seq.sv
module latched_sram_seq #(
  parameter int SETUP_CYC = 1,
  parameter int GATE_LOW  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       wr,
  input  logic [15:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       done,
  output logic [7:0] bus_dout,
  output logic       bus_doe,
  input  logic [7:0] bus_din,
  output logic       gate_n,
  output logic [2:0] sel,
  output logic       ctl_oe
);

  localparam int CNT_MAX = (SETUP_CYC > GATE_LOW) ? SETUP_CYC : GATE_LOW;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [2:0] SEL_LO = 3'b010;
  localparam logic [2:0] SEL_HI = 3'b011;
  localparam logic [2:0] SEL_WR = 3'b111;
  localparam logic [2:0] SEL_RD = 3'b000;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_LOW, S_REC} st_t;

  st_t         st;
  logic [1:0]  ph;
  logic [CW-1:0] cnt;
  logic [15:0] a_q;
  logic [7:0]  d_q;
  logic        wr_q;
  logic [7:0]  rd_q;
  logic        done_q;

  wire last_ph = (ph == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= 2'd0;
      cnt    <= '0;
      a_q    <= '0;
      d_q    <= '0;
      wr_q   <= 1'b0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          a_q  <= addr;
          d_q  <= wdata;
          wr_q <= wr;
          ph   <= 2'd0;
          cnt  <= '0;
          st   <= S_SETUP;
        end
        S_SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin
          cnt <= '0;
          st  <= S_LOW;
        end else cnt <= cnt + CW'(1);
        S_LOW: if (cnt == CW'(GATE_LOW - 1)) begin
          cnt <= '0;
          st  <= S_REC;
          if (last_ph && !wr_q) rd_q <= bus_din;
        end else cnt <= cnt + CW'(1);
        S_REC: if (last_ph) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end else begin
          ph <= ph + 2'd1;
          st <= S_SETUP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ctl_oe   = (st != S_IDLE);
  assign gate_n   = (st != S_LOW);
  assign sel      = !ctl_oe ? 3'b000 :
                    (ph == 2'd0) ? SEL_LO :
                    (ph == 2'd1) ? SEL_HI :
                    wr_q ? SEL_WR : SEL_RD;
  assign bus_doe  = ctl_oe && !(last_ph && !wr_q);
  assign bus_dout = !bus_doe ? 8'h00 :
                    (ph == 2'd0) ? a_q[7:0] :
                    (ph == 2'd1) ? a_q[15:8] : d_q;
  assign rdata    = rd_q;
  assign done     = done_q;

  assert_read_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_n && sel == SEL_RD) |-> !bus_doe);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ctl_oe && !bus_doe && gate_n));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |=> $stable(a_q));

  assert_gate_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_n) |-> ($stable(sel) && $past(ctl_oe)));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |=> $stable(rdata));

endmodule

// File: tb/sim_latched_sram_seq.sv
`timescale 1ns/1ps
module sim_latched_sram_seq;
  localparam int S = 2;
  localparam int G = 3;
  localparam int LAT = 3 * (S + G + 1);

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, bus_dout, bus_din;
  logic done, bus_doe, gate_n, ctl_oe;
  logic [2:0] sel;

  always #2.5 clk = ~clk;

  latched_sram_seq #(.SETUP_CYC(S), .GATE_LOW(G)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .gate_n(gate_n), .sel(sel), .ctl_oe(ctl_oe));

  int n_chk = 0, n_fail = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] lat_lo = 0, lat_hi = 0;
  logic [7:0] mem [256];
  logic [7:0] tagm [256];
  logic       vld [256];

  function automatic logic [7:0] bg(logic [7:0] lo, logic [7:0] hi);
    return lo ^ {hi[3:0], hi[7:4]} ^ 8'h5A;
  endfunction

  assign bus_din = (ctl_oe && !gate_n && sel == 3'b000) ?
                   ((vld[lat_lo] && tagm[lat_lo] == lat_hi) ? mem[lat_lo] : bg(lat_lo, lat_hi))
                   : 8'hEE;

  int npulse = 0, low_run = 0, setup_run = 0;
  logic prev_hi = 0;
  logic [2:0] prev_sel = 0;
  logic [2:0] codes [3];
  logic [7:0] pdata [3];

  always @(negedge clk) if (rst_n) begin
    if (ctl_oe && !gate_n) begin
      low_run++;
      if (low_run == 1) begin
        check(setup_run == S, "R4 setup", setup_run, S);
        if (npulse < 3) begin codes[npulse] = sel; pdata[npulse] = bus_dout; end
        npulse++;
      end
      case (sel)
        3'b010: lat_lo = bus_dout;
        3'b011: lat_hi = bus_dout;
        3'b111: if (bus_doe) begin mem[lat_lo] = bus_dout; tagm[lat_lo] = lat_hi; vld[lat_lo] = 1; end
        3'b000: if (low_run == 1) check(!bus_doe, "R5 drive", bus_doe, 0);
        default: ;
      endcase
      prev_hi = 0;
    end else begin
      if (low_run != 0) check(low_run == G, "R4 low", low_run, G);
      low_run = 0;
      if (ctl_oe) begin
        setup_run = (prev_hi && sel == prev_sel) ? setup_run + 1 : 1;
        prev_hi = 1;
      end else prev_hi = 0;
    end
    prev_sel = sel;
  end

  task automatic access(bit w, logic [15:0] a, logic [7:0] d, output logic [7:0] rd, input bit poke);
    int n;
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d; npulse = 0;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    n = 0;
    do begin
      if (poke && n == 3) begin req = 1; wr = 1; addr = 16'hA5C3; wdata = 8'h99; end
      if (poke && n == 6) req = 0;
      @(posedge clk); n++;
      @(negedge clk);
    end while (!done && n < 100);
    check(n == LAT, "R6 latency", n, LAT);
    check(npulse == 3, "R2 pulses", npulse, 3);
    check(codes[0] == 3'b010 && pdata[0] == a[7:0], "R2 low byte", pdata[0], a[7:0]);
    check(codes[1] == 3'b011 && pdata[1] == a[15:8], "R2 high byte", pdata[1], a[15:8]);
    check(codes[2] == (w ? 3'b111 : 3'b000), "R3 code", codes[2], w ? 7 : 0);
    if (w) check(pdata[2] == d, "R3 wdata", pdata[2], d);
    check(!ctl_oe && !bus_doe && gate_n, "R7 release", {ctl_oe, bus_doe, gate_n}, 1);
    @(negedge clk);
    check(!done, "R6 one cycle", done, 0);
    check(!ctl_oe && !bus_doe && gate_n, "R7 idle", {ctl_oe, bus_doe, gate_n}, 1);
    rd = rdata;
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r, r0;
    for (int i = 0; i < 256; i++) begin vld[i] = 0; mem[i] = 0; tagm[i] = 0; end
    repeat (3) @(negedge clk);
    check(!ctl_oe && !bus_doe && gate_n && !done, "R1 in reset", {ctl_oe, bus_doe, gate_n, done}, 2);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!ctl_oe && !bus_doe && gate_n && !done, "R1 after reset", {ctl_oe, bus_doe, gate_n, done}, 2);

    for (int lo = 0; lo < 256; lo++)
      access(1, {8'h12, 8'(lo)}, 8'(lo * 7 + 8'h12), r, lo == 40);
    for (int lo = 0; lo < 256; lo++) begin
      access(0, {8'h12, 8'(lo)}, 8'h00, r, 0);
      check(r == 8'(lo * 7 + 8'h12), "R5 readback", r, 8'(lo * 7 + 8'h12));
    end
    for (int lo = 0; lo < 256; lo++) begin
      access(0, {8'h9C, 8'(lo)}, 8'h00, r, 0);
      check(r == bg(8'(lo), 8'h9C), "R2 unwritten", r, bg(8'(lo), 8'h9C));
    end
    access(0, 16'hA5C3, 8'h00, r, 0);
    check(r == bg(8'hC3, 8'hA5), "R8 busy request ignored", r, bg(8'hC3, 8'hA5));
    access(0, 16'h12C3, 8'h00, r, 0);
    check(r == 8'(8'hC3 * 7 + 8'h12), "R8 target intact", r, 8'(8'hC3 * 7 + 8'h12));

    for (int h = 0; h < 256; h++) begin
      access(1, {8'(h), 8'h77}, 8'(h ^ 8'h3C), r, 0);
      access(0, {8'(h), 8'h77}, 8'h00, r, 0);
      check(r == 8'(h ^ 8'h3C), "R5 high sweep", r, 8'(h ^ 8'h3C));
    end

    r0 = rdata;
    repeat (5) @(negedge clk);
    check(rdata == r0, "R9 hold idle", rdata, r0);
    access(1, 16'h0101, 8'hF0, r, 0);
    check(r == r0, "R9 hold over write", r, r0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule